// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits passively on the command pins of a four-bank synchronous DRAM bus. It decodes chip select, row strobe, column strobe, write enable, the bank-select bits and address bit 10 on every rising clock edge. It keeps a state for each bank: closed, open, or closing after an auto-precharge. It also keeps two device-wide lockout windows, one after a refresh and one after a mode-register write. When a command cannot be accepted in the present state, the block flags it.

A flagged command produces a one-cycle error pulse and a code that names the kind of violation. A flagged command changes no tracked state. The open/closed status of every bank is visible on an output vector. All timing is counted in clock cycles. The refresh recovery time, the mode-register recovery time and the auto-precharge closing delay are set by parameters. The block drives nothing onto the memory bus.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Command encoding, sampled at a rising edge. cs_n high is a deselect, treated the same as a no-op. With cs_n low, {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode-register set. Deselect and no-op are legal in every state and never raise an error.
- R2: A read or write is legal only when the selected bank is open and has no auto-precharge pending. Otherwise err_code is 1.
- R3: An activate to a bank that is not closed gives err_code 2. A legal activate sets that bank's bit in bank_open.
- R4: A mode-register set while any bank is open or still closing gives err_code 2.
- R5: A refresh while any bank is open or still closing gives err_code 2.
- R6: A legal precharge with a10 high closes every bank. With a10 low it closes only the bank selected by ba.
- R7: After a legal refresh at edge k, only deselect, no-op and burst stop are accepted at edges k+1 to k+T_RC-1. Any other command in that window gives err_code 3. Commands are accepted again from edge k+T_RC.
- R8: After a legal mode-register set at edge k, only deselect and no-op are accepted at edges k+1 to k+T_MRD-1. Any other command in that window, burst stop included, gives err_code 4.
- R9: A legal read or write with a10 high at edge k starts closing its bank. The bank's bank_open bit clears after edge k+T_AP-1. An activate to that bank is flagged with code 2 before edge k+T_AP and is legal at edge k+T_AP.
- R10: err_pulse and err_code are registered. They show the verdict on the command at edge k during the cycle after edge k. err_pulse is high exactly when err_code is nonzero. A flagged command leaves the bank and lockout state unchanged. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank select |
| a10 | input | 1 | Address bit 10: selects auto-precharge or precharge-all |
| err_pulse | output | 1 | One-cycle flag for an illegal command |
| err_code | output | 3 | 0 none, 1 column command to a bank not open, 2 bank open, 3 refresh lockout, 4 mode-register lockout |
| bank_open | output | NUM_BANKS (4) | One bit per bank, set while the bank is open or closing |

## Verification
Two events can meet at the same edge: the auto-precharge timer of a bank reaching its end, and a new activate to that bank. The bench issues an auto-precharge write and then an activate one cycle after it, which must be flagged. It then issues an activate exactly T_AP edges after the write, which must be accepted, and expects that bank to show open again. A precharge is also issued while an auto-precharge countdown is still running, and the bench expects the bank to close at once.

// File: rtl/sdcm_pkg.sv
package sdcm_pkg;

   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_BST = 3'd1,
      CMD_RD  = 3'd2,
      CMD_WR  = 3'd3,
      CMD_ACT = 3'd4,
      CMD_PRE = 3'd5,
      CMD_REF = 3'd6,
      CMD_MRS = 3'd7
   } cmd_e;

   typedef enum logic [2:0] {
      ERR_NONE       = 3'd0,
      ERR_COL_CLOSED = 3'd1,
      ERR_BANK_OPEN  = 3'd2,
      ERR_REF_LOCK   = 3'd3,
      ERR_MRS_LOCK   = 3'd4
   } err_e;

   typedef enum logic [1:0] {
      BK_CLOSED  = 2'd0,
      BK_OPEN    = 2'd1,
      BK_CLOSING = 2'd2
   } bank_st_e;

endpackage

// File: rtl/sdcm_decode.sv
module sdcm_decode
   import sdcm_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_NOP;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b110:  cmd = CMD_BST;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b011:  cmd = CMD_ACT;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            default: cmd = CMD_MRS;
         endcase
      end
   end

endmodule

// File: rtl/sdcm_lockout.sv
module sdcm_lockout #(
   parameter int unsigned SPAN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);

   generate
      if (SPAN < 2) begin : g_none
         assign busy = 1'b0;
      end else begin : g_cnt
         localparam int unsigned CW = $clog2(SPAN);
         localparam logic [CW-1:0] LOAD = CW'(SPAN - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (start) begin
               cnt <= LOAD;
            end else if (cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end

         assign busy = (cnt != '0);
      end
   endgenerate

endmodule

// File: rtl/sdcm_bank.sv
module sdcm_bank
   import sdcm_pkg::*;
#(
   parameter int unsigned T_AP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic do_act,
   input  logic do_col_ap,
   input  logic do_pre,
   output logic col_ok,
   output logic act_ok,
   output logic open_o
);

   localparam int unsigned CW = $clog2(T_AP + 1);
   localparam logic [CW-1:0] LOAD = CW'(T_AP - 1);

   bank_st_e      st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= BK_CLOSED;
         cnt <= '0;
      end else begin
         case (st)
            BK_CLOSED: begin
               if (do_act) st <= BK_OPEN;
            end
            BK_OPEN: begin
               if (do_pre) begin
                  st <= BK_CLOSED;
               end else if (do_col_ap) begin
                  st  <= BK_CLOSING;
                  cnt <= LOAD;
               end
            end
            BK_CLOSING: begin
               if (do_pre) begin
                  st  <= BK_CLOSED;
                  cnt <= '0;
               end else if (do_act) begin
                  st <= BK_OPEN;
               end else if (cnt == '0) begin
                  st <= BK_CLOSED;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= BK_CLOSED;
         endcase
      end
   end

   assign col_ok = (st == BK_OPEN);
   assign act_ok = (st == BK_CLOSED) || ((st == BK_CLOSING) && (cnt == '0));
   assign open_o = (st == BK_OPEN) || ((st == BK_CLOSING) && (cnt != '0));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdcm_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned T_RC      = 7,
   parameter int unsigned T_MRD     = 2,
   parameter int unsigned T_AP      = 4,
   localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            ras_n,
   input  logic            cas_n,
   input  logic            we_n,
   input  logic [BA_W-1:0] ba,
   input  logic            a10,
   output logic            err_pulse,
   output logic [2:0]      err_code,
   output logic [NUM_BANKS-1:0] bank_open
);

   generate
      if (NUM_BANKS < 2 || (1 << BA_W) != NUM_BANKS) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two of at least 2");
      end
      if (T_RC < 1 || T_MRD < 1 || T_AP < 1) begin : g_bad_timing
         $error("T_RC, T_MRD and T_AP must each be at least 1");
      end
   endgenerate

   cmd_e                 cmd;
   err_e                 err_now;
   logic                 legal;
   logic                 ref_busy;
   logic                 mrs_busy;
   logic [NUM_BANKS-1:0] col_ok;
   logic [NUM_BANKS-1:0] act_ok;

   sdcm_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   always_comb begin
      err_now = ERR_NONE;
      if (ref_busy) begin
         if (cmd != CMD_NOP && cmd != CMD_BST) err_now = ERR_REF_LOCK;
      end else if (mrs_busy) begin
         if (cmd != CMD_NOP) err_now = ERR_MRS_LOCK;
      end else begin
         case (cmd)
            CMD_RD, CMD_WR: if (!col_ok[ba]) err_now = ERR_COL_CLOSED;
            CMD_ACT:        if (!act_ok[ba]) err_now = ERR_BANK_OPEN;
            CMD_REF, CMD_MRS: if (!(&act_ok)) err_now = ERR_BANK_OPEN;
            default:        err_now = ERR_NONE;
         endcase
      end
   end

   assign legal = (err_now == ERR_NONE);

   sdcm_lockout #(.SPAN(T_RC)) u_ref_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (legal && cmd == CMD_REF),
      .busy  (ref_busy)
   );

   sdcm_lockout #(.SPAN(T_MRD)) u_mrs_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .start (legal && cmd == CMD_MRS),
      .busy  (mrs_busy)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
         logic sel;
         assign sel = (ba == BA_W'(gi));

         sdcm_bank #(.T_AP(T_AP)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .do_act    (legal && cmd == CMD_ACT && sel),
            .do_col_ap (legal && (cmd == CMD_RD || cmd == CMD_WR) && a10 && sel),
            .do_pre    (legal && cmd == CMD_PRE && (a10 || sel)),
            .col_ok    (col_ok[gi]),
            .act_ok    (act_ok[gi]),
            .open_o    (bank_open[gi])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_pulse <= 1'b0;
         err_code  <= 3'd0;
      end else begin
         err_pulse <= !legal;
         err_code  <= err_now;
      end
   end

endmodule

// File: rtl/sdcm_checker.sv
module sdcm_checker #(
   parameter int unsigned NB   = 4,
   parameter int unsigned BW   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          ras_n,
   input logic          cas_n,
   input logic          we_n,
   input logic [BW-1:0] ba,
   input logic          a10,
   input logic          err_pulse,
   input logic [2:0]    err_code,
   input logic [NB-1:0] bank_open,
   input logic          ref_busy,
   input logic          mrs_busy
);

   logic col_cmd, act_cmd, pre_cmd, nop_like;
   assign col_cmd  = !cs_n && ras_n && !cas_n;
   assign act_cmd  = !cs_n && !ras_n && cas_n && we_n;
   assign pre_cmd  = !cs_n && !ras_n && cas_n && !we_n;
   assign nop_like = cs_n || (ras_n && cas_n && we_n);

   AST_DESL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      nop_like |=> !err_pulse); // R1

   AST_COL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (col_cmd && !bank_open[ba] && !ref_busy && !mrs_busy) |=> (err_code == 3'd1)); // R2

   AST_ACT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (act_cmd && bank_open[ba]) |=> (err_pulse && err_code == 3'd2)); // R3

   AST_PREALL_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_cmd && a10 && !ref_busy && !mrs_busy) |=> (bank_open == '0)); // R6

   AST_REF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_busy && (act_cmd || pre_cmd)) |=> (err_code == 3'd3)); // R7

   AST_MRS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mrs_busy && !nop_like) |=> (err_code == 3'd4)); // R8

   AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ref_busy && mrs_busy)); // R7

   AST_PULSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse == (err_code != 3'd0)); // R10

endmodule

bind sdram_cmd_monitor sdcm_checker #(.NB(NUM_BANKS), .BW(BA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .a10       (a10),
   .err_pulse (err_pulse),
   .err_code  (err_code),
   .bank_open (bank_open),
   .ref_busy  (ref_busy),
   .mrs_busy  (mrs_busy)
);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;

   localparam int unsigned T_RC  = 4;
   localparam int unsigned T_MRD = 3;
   localparam int unsigned T_AP  = 3;

   // {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] P_DESL = 4'b1000;
   localparam logic [3:0] P_NOP  = 4'b0111;
   localparam logic [3:0] P_BST  = 4'b0110;
   localparam logic [3:0] P_RD   = 4'b0101;
   localparam logic [3:0] P_WR   = 4'b0100;
   localparam logic [3:0] P_ACT  = 4'b0011;
   localparam logic [3:0] P_PRE  = 4'b0010;
   localparam logic [3:0] P_REF  = 4'b0001;
   localparam logic [3:0] P_MRS  = 4'b0000;

   typedef struct {
      logic [2:0] code;
      logic [3:0] mask;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = 2'd0;
   logic       a10 = 1'b0;
   logic       err_pulse;
   logic [2:0] err_code;
   logic [3:0] bank_open;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   sdram_cmd_monitor #(.NUM_BANKS(4), .T_RC(T_RC), .T_MRD(T_MRD), .T_AP(T_AP)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .ba        (ba),
      .a10       (a10),
      .err_pulse (err_pulse),
      .err_code  (err_code),
      .bank_open (bank_open)
   );

   task automatic issue(input logic [3:0] p, input logic [1:0] b, input logic a,
                        input logic [2:0] ec, input logic [3:0] em, input string tag);
      exp_t e;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = p;
      ba  = b;
      a10 = a;
      e.code = ec;
      e.mask = em;
      e.tag  = tag;
      q.push_back(e);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #3;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (err_code !== e.code || err_pulse !== (e.code != 3'd0) || bank_open !== e.mask) begin
               errors++;
               $display("FAIL %s: got code=%0d pulse=%0b open=%b, expected code=%0d pulse=%0b open=%b",
                        e.tag, err_code, err_pulse, bank_open, e.code, (e.code != 3'd0), e.mask);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (err_pulse !== 1'b0 || err_code !== 3'd0 || bank_open !== 4'b0000) begin
         errors++;
         $display("FAIL R10 reset: got pulse=%0b code=%0d open=%b, expected 0 0 0000",
                  err_pulse, err_code, bank_open);
      end
      rst_n = 1'b1;

      issue(P_RD,  2'd0, 1'b0, 3'd1, 4'b0000, "R2 read closed bank");
      issue(P_WR,  2'd2, 1'b1, 3'd1, 4'b0000, "R2 write-ap closed bank");
      issue(P_ACT, 2'd1, 1'b0, 3'd0, 4'b0010, "R3 activate closed bank");
      issue(P_ACT, 2'd1, 1'b0, 3'd2, 4'b0010, "R3 activate open bank");
      issue(P_RD,  2'd1, 1'b0, 3'd0, 4'b0010, "R2 read open bank");
      issue(P_MRS, 2'd0, 1'b0, 3'd2, 4'b0010, "R4 mode set with open bank");
      issue(P_REF, 2'd0, 1'b0, 3'd2, 4'b0010, "R5 refresh with open bank");
      issue(P_ACT, 2'd3, 1'b0, 3'd0, 4'b1010, "R3 activate second bank");
      issue(P_PRE, 2'd1, 1'b0, 3'd0, 4'b1000, "R6 precharge single bank");
      issue(P_ACT, 2'd0, 1'b0, 3'd0, 4'b1001, "R3 activate bank0");
      issue(P_PRE, 2'd2, 1'b1, 3'd0, 4'b0000, "R6 precharge all");
      // refresh lockout: T_RC=4, edges +1..+3 locked
      issue(P_REF, 2'd0, 1'b0, 3'd0, 4'b0000, "R5 refresh all closed");
      issue(P_BST, 2'd0, 1'b0, 3'd0, 4'b0000, "R7 burst stop in refresh window");
      issue(P_ACT, 2'd0, 1'b0, 3'd3, 4'b0000, "R7 activate in refresh window");
      issue(P_NOP, 2'd0, 1'b0, 3'd0, 4'b0000, "R1 no-op in refresh window");
      issue(P_ACT, 2'd0, 1'b0, 3'd0, 4'b0001, "R7 activate at window end");
      issue(P_PRE, 2'd0, 1'b1, 3'd0, 4'b0000, "R6 precharge all again");
      // mode-register lockout: T_MRD=3, edges +1..+2 locked
      issue(P_MRS, 2'd0, 1'b0, 3'd0, 4'b0000, "R8 mode set legal");
      issue(P_BST, 2'd0, 1'b0, 3'd4, 4'b0000, "R8 burst stop in mode window");
      issue(P_REF, 2'd0, 1'b0, 3'd4, 4'b0000, "R8 refresh in mode window");
      issue(P_ACT, 2'd2, 1'b0, 3'd0, 4'b0100, "R8 activate after mode window");
      // auto-precharge: T_AP=3
      issue(P_WR,  2'd2, 1'b1, 3'd0, 4'b0100, "R9 write with auto-precharge");
      issue(P_ACT, 2'd2, 1'b0, 3'd2, 4'b0100, "R9 early activate while closing");
      issue(P_NOP, 2'd2, 1'b0, 3'd0, 4'b0000, "R9 bank shown closed");
      issue(P_ACT, 2'd2, 1'b0, 3'd0, 4'b0100, "R9 activate at close edge");
      issue(P_RD,  2'd2, 1'b1, 3'd0, 4'b0100, "R9 read with auto-precharge");
      issue(P_RD,  2'd2, 1'b0, 3'd1, 4'b0100, "R2 read while closing");
      issue(P_PRE, 2'd2, 1'b0, 3'd0, 4'b0000, "R6 precharge during closing");
      issue(P_NOP, 2'd0, 1'b0, 3'd0, 4'b0000, "R1 idle no-op");
      issue(P_DESL & 4'b1000, 2'd3, 1'b1, 3'd0, 4'b0000, "R1 deselect with strobes low");
      issue(P_NOP, 2'd0, 1'b0, 3'd0, 4'b0000, "R10 no stray pulse");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule